// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller (Five-State)

This block keeps one private write-back, write-allocate cache coherent with its peers on a shared snooping bus. It holds a direct-mapped array of line entries, each with a 3-bit coherence state (Invalid, Shared, Exclusive, Owned, Modified), a tag and one data word of parameterised width. The processor side issues reads and writes. The controller finishes hits locally. On a miss or an ownership change it goes to the bus with a read, a read-for-ownership, an upgrade or a writeback.

The controller also watches every transaction that other caches place on the bus. It updates the matching line and answers in the next cycle: a "holding" flag, plus a "supplying" flag and data when it has the dirty copy. A dirty line that another cache reads becomes Owned. It stays dirty and is not written to memory, so one cache can pass dirty data straight to another. Memory gets the line back only when the line is evicted.

The bus arbiter, the memory and the other caches sit outside the block. They are expected to keep the bus serialized, with one transaction in flight at a time.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. The first access to any address goes to the bus, and a snoop to any address returns neither holding nor supplying.
- R2: The processor side is valid/ready. A request is taken in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low from that cycle until the cycle in which `rsp_valid` pulses for exactly one cycle, and it is high again in that cycle. A requester that sees `req_ready` low must hold its request.
- R3: A read miss issues a read (command 0) with the request address. The line fills Exclusive when `mst_ack_shared` is 0 and Shared when it is 1, and `rsp_rdata` returns `mst_ack_data`. A later read of the same address completes with no bus request.
- R4: A write that hits a line in Exclusive or Modified completes with no bus request and leaves the line Modified.
- R5: A write that hits a line in Shared or Owned issues an upgrade (command 2), not a read-for-ownership, and leaves the line Modified with the new data.
- R6: A write miss issues a read-for-ownership (command 1) with the request address and fills the line Modified with the write data.
- R7: On a miss whose victim is Modified or Owned, a writeback (command 3) carrying the victim's address and data is issued and acknowledged before the refill request is raised. A clean victim is dropped with no bus traffic.
- R8: A snooped read (command 0) to a held line raises `snp_shared` in the next cycle. If the line is Modified or Owned, `snp_supply` is also raised with the line data in `snp_data`, and the line becomes Owned. An Exclusive line becomes Shared.
- R9: A snooped read-for-ownership (command 1) to a held line raises `snp_shared` in the next cycle, supplies data when the line is Modified or Owned, and invalidates the line.
- R10: A snooped upgrade (command 2) to a held line raises `snp_shared` and invalidates the line without supplying data. A snooped writeback (command 3) gets no response and changes nothing.
- R11: The bus request `mst_req` stays high until a cycle with `mst_gnt`. The transaction is then presented in the next cycle with `mst_valid` high for exactly one cycle, and `mst_req` stays low until `mst_ack` has been received.
- R12: A snoop takes effect before the local operation that competes with it. A snoop arriving in the cycle of the local lookup stalls that lookup by one cycle, so the lookup sees the updated state. The bus command is chosen from the line state at grant time, so a Shared line invalidated while waiting for grant turns an upgrade into a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low bits are the line index |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, or the written data for a write |
| mst_req | output | 1 | Bus request to the arbiter |
| mst_gnt | input | 1 | Bus grant |
| mst_valid | output | 1 | Own transaction on the bus |
| mst_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| mst_addr | output | ADDR_W | Transaction address |
| mst_wdata | output | DATA_W | Writeback data |
| mst_ack | input | 1 | Transaction complete, snoop window closed |
| mst_ack_data | input | DATA_W | Fill data from memory or an owner |
| mst_ack_shared | input | 1 | Some other cache holds the line |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `mst_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line (next cycle) |
| snp_supply | output | 1 | This cache supplies the dirty data (next cycle) |
| snp_data | output | DATA_W | Supplied data |

## Verification
The assertions assume a serialized bus. A grant is given only while a request is pending. An acknowledge arrives only for this controller's own presented transaction. No snoop arrives while the controller's own transaction is between grant and acknowledge. The bench keeps to these rules by acting as arbiter, memory and peer caches from a single sequence of tasks. Snoops are issued either when the controller is idle, or at two chosen points: the lookup cycle and the wait for grant.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_UPG = 2'd2,
    BUS_WB  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_LOOK = 2'd1,
    C_REQ  = 2'd2,
    C_WAIT = 2'd3
  } ctl_st_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(LINES)-1:0]  lk_idx,
  output line_st_e                  lk_st,
  output logic [TAG_W-1:0]          lk_tag,
  output logic [DATA_W-1:0]         lk_data,
  input  logic [$clog2(LINES)-1:0]  sn_idx,
  output line_st_e                  sn_st,
  output logic [TAG_W-1:0]          sn_tag,
  output logic [DATA_W-1:0]         sn_data,
  input  logic                      lw_en,
  input  logic [$clog2(LINES)-1:0]  lw_idx,
  input  line_st_e                  lw_st,
  input  logic [TAG_W-1:0]          lw_tag,
  input  logic [DATA_W-1:0]         lw_data,
  input  logic                      sw_en,
  input  line_st_e                  sw_st
);
  localparam int IDX_W = $clog2(LINES);

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign lk_st   = st_q[lk_idx];
  assign lk_tag  = tag_q[lk_idx];
  assign lk_data = data_q[lk_idx];
  assign sn_st   = st_q[sn_idx];
  assign sn_tag  = tag_q[sn_idx];
  assign sn_data = data_q[sn_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else begin
        if (lw_en && (lw_idx == IDX_W'(g))) begin
          st_q[g]   <= lw_st;
          tag_q[g]  <= lw_tag;
          data_q[g] <= lw_data;
        end
        // snoop update is placed last: it wins the state on a collision
        if (sw_en && (sn_idx == IDX_W'(g))) begin
          st_q[g] <= sw_st;
        end
      end
    end
  end
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int DATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                snp_valid,
  input  logic [1:0]                          snp_cmd,
  input  logic [ADDR_W-1:0]                   snp_addr,
  output logic [$clog2(LINES)-1:0]            sn_idx,
  input  line_st_e                            sn_st,
  input  logic [ADDR_W-$clog2(LINES)-1:0]     sn_tag,
  input  logic [DATA_W-1:0]                   sn_data,
  output logic                                sw_en,
  output line_st_e                            sw_st,
  output logic                                snp_shared,
  output logic                                snp_supply,
  output logic [DATA_W-1:0]                   snp_data
);
  localparam int IDX_W = $clog2(LINES);

  bus_cmd_e cmd;
  logic     holds;
  logic     dirty;
  logic     respond;
  logic     give;

  assign cmd     = bus_cmd_e'(snp_cmd);
  assign sn_idx  = snp_addr[IDX_W-1:0];
  assign holds   = snp_valid && (sn_st != ST_I) && (sn_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign dirty   = is_dirty(sn_st);
  assign respond = holds && (cmd != BUS_WB);
  assign give    = respond && dirty && (cmd != BUS_UPG);

  always_comb begin
    sw_en = respond;
    unique case (cmd)
      BUS_RD:  sw_st = dirty ? ST_O : ST_S;
      BUS_RDX: sw_st = ST_I;
      BUS_UPG: sw_st = ST_I;
      default: sw_st = sn_st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_shared <= 1'b0;
      snp_supply <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_shared <= respond;
      snp_supply <= give;
      snp_data   <= give ? sn_data : '0;
    end
  end
endmodule

// File: rtl/moesi_proc_fsm.sv
module moesi_proc_fsm
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  output logic                              rsp_valid,
  output logic [DATA_W-1:0]                 rsp_rdata,
  output logic                              mst_req,
  input  logic                              mst_gnt,
  output logic                              mst_valid,
  output logic [1:0]                        mst_cmd,
  output logic [ADDR_W-1:0]                 mst_addr,
  output logic [DATA_W-1:0]                 mst_wdata,
  input  logic                              mst_ack,
  input  logic [DATA_W-1:0]                 mst_ack_data,
  input  logic                              mst_ack_shared,
  input  logic                              snp_valid,
  output logic [$clog2(LINES)-1:0]          lk_idx,
  input  line_st_e                          lk_st,
  input  logic [ADDR_W-$clog2(LINES)-1:0]   lk_tag,
  input  logic [DATA_W-1:0]                 lk_data,
  output logic                              lw_en,
  output line_st_e                          lw_st,
  output logic [ADDR_W-$clog2(LINES)-1:0]   lw_tag,
  output logic [DATA_W-1:0]                 lw_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_e            state_q;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  bus_cmd_e           cmd_q;

  logic [TAG_W-1:0]   req_tag;
  logic               hit;
  logic               local_done;
  logic               need_wb;
  bus_cmd_e           sel_cmd;

  assign lk_idx     = addr_q[IDX_W-1:0];
  assign req_tag    = addr_q[ADDR_W-1:IDX_W];
  assign hit        = (lk_st != ST_I) && (lk_tag == req_tag);
  assign local_done = hit && (!wr_q || (lk_st == ST_E) || (lk_st == ST_M));
  assign need_wb    = !hit && is_dirty(lk_st);

  always_comb begin
    if (need_wb)          sel_cmd = BUS_WB;
    else if (wr_q && hit) sel_cmd = BUS_UPG;
    else if (wr_q)        sel_cmd = BUS_RDX;
    else                  sel_cmd = BUS_RD;
  end

  assign req_ready = (state_q == C_IDLE);
  assign mst_req   = (state_q == C_REQ);
  assign mst_cmd   = cmd_q;

  always_comb begin
    lw_en   = 1'b0;
    lw_st   = lk_st;
    lw_tag  = req_tag;
    lw_data = lk_data;
    if (state_q == C_LOOK && !snp_valid && local_done && wr_q) begin
      lw_en   = 1'b1;
      lw_st   = ST_M;
      lw_data = wdata_q;
    end else if (state_q == C_WAIT && mst_ack) begin
      lw_en = 1'b1;
      unique case (cmd_q)
        BUS_WB: begin
          lw_st  = ST_I;
          lw_tag = lk_tag;
        end
        BUS_RD: begin
          lw_st   = mst_ack_shared ? ST_S : ST_E;
          lw_data = mst_ack_data;
        end
        default: begin
          lw_st   = ST_M;
          lw_data = wdata_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= C_IDLE;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cmd_q     <= BUS_RD;
      mst_valid <= 1'b0;
      mst_addr  <= '0;
      mst_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mst_valid <= 1'b0;
      unique case (state_q)
        C_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state_q <= C_LOOK;
          end
        end
        C_LOOK: begin
          if (!snp_valid) begin
            if (local_done) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= wr_q ? wdata_q : lk_data;
              state_q   <= C_IDLE;
            end else begin
              state_q <= C_REQ;
            end
          end
        end
        C_REQ: begin
          if (mst_gnt) begin
            mst_valid <= 1'b1;
            cmd_q     <= sel_cmd;
            mst_addr  <= need_wb ? {lk_tag, lk_idx} : addr_q;
            mst_wdata <= need_wb ? lk_data : '0;
            state_q   <= C_WAIT;
          end
        end
        default: begin
          if (mst_ack) begin
            if (cmd_q == BUS_WB) begin
              state_q <= C_REQ;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= (cmd_q == BUS_RD) ? mst_ack_data : wdata_q;
              state_q   <= C_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mst_req,
  input  logic              mst_gnt,
  output logic              mst_valid,
  output logic [1:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic              mst_ack,
  input  logic [DATA_W-1:0] mst_ack_data,
  input  logic              mst_ack_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, sn_idx;
  line_st_e          lk_st, sn_st, lw_st, sw_st;
  logic [TAG_W-1:0]  lk_tag, sn_tag, lw_tag;
  logic [DATA_W-1:0] lk_data, sn_data, lw_data;
  logic              lw_en, sw_en;

  moesi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_st(lk_st), .lk_tag(lk_tag), .lk_data(lk_data),
    .sn_idx(sn_idx), .sn_st(sn_st), .sn_tag(sn_tag), .sn_data(sn_data),
    .lw_en(lw_en), .lw_idx(lk_idx), .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data),
    .sw_en(sw_en), .sw_st(sw_st)
  );

  moesi_snoop_unit #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .sn_idx(sn_idx), .sn_st(sn_st), .sn_tag(sn_tag), .sn_data(sn_data),
    .sw_en(sw_en), .sw_st(sw_st),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  moesi_proc_fsm #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mst_req(mst_req), .mst_gnt(mst_gnt), .mst_valid(mst_valid), .mst_cmd(mst_cmd),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_ack(mst_ack), .mst_ack_data(mst_ack_data), .mst_ack_shared(mst_ack_shared),
    .snp_valid(snp_valid),
    .lk_idx(lk_idx), .lk_st(lk_st), .lk_tag(lk_tag), .lk_data(lk_data),
    .lw_en(lw_en), .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data)
  );
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       mst_req,
  input logic       mst_gnt,
  input logic       mst_valid,
  input logic       mst_ack,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_shared,
  input logic       snp_supply
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_rsp_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(req_ready));

  a_r2_ready_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  a_r11_present_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && mst_gnt) |=> mst_valid);

  a_r11_single_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |=> !mst_valid);

  a_r11_no_req_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> !mst_req);

  a_r11_no_req_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && !mst_ack) |=> !mst_req);

  a_r8_supply_needs_holding: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);

  a_r9_response_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> $past(snp_valid));

  a_r10_wb_snoop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |=> (!snp_shared && !snp_supply));

  a_r10_upg_never_supplies: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd2) |=> !snp_supply);
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk chk_i (.*);

// File: tb/moesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int MI = 0, MS = 1, ME = 2, MO = 3, MM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic mst_req, mst_valid;
  logic mst_gnt = 0, mst_ack = 0, mst_ack_shared = 0;
  logic [DW-1:0] mst_ack_data = '0;
  logic [1:0] mst_cmd;
  logic [AW-1:0] mst_addr;
  logic [DW-1:0] mst_wdata;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  int checks = 0, fails = 0, cycles = 0;

  int m_st [8];
  logic [6:0] m_tag [8];
  logic [DW-1:0] m_dat [8];
  logic [DW-1:0] mem [int];
  logic exp_sh = 0, exp_sup = 0;
  logic [DW-1:0] exp_dat = '0;

  always #2.5 clk = ~clk;

  moesi_snoop_ctrl #(.ADDR_W(AW), .LINES(8), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mst_req(mst_req), .mst_gnt(mst_gnt), .mst_valid(mst_valid), .mst_cmd(mst_cmd),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_ack(mst_ack), .mst_ack_data(mst_ack_data), .mst_ack_shared(mst_ack_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return DW'(16'hA000) ^ DW'(a);
  endfunction

  // behavioural reference: next bus command expected for an access, -1 = none
  function automatic int plan(input bit wr, input logic [AW-1:0] a);
    int i = int'(a[2:0]);
    bit hit = (m_st[i] != MI) && (m_tag[i] == a[9:3]);
    if (hit && (!wr || m_st[i] == ME || m_st[i] == MM)) return -1;
    if (!hit && (m_st[i] == MM || m_st[i] == MO)) return 3;
    if (wr && hit) return 2;
    if (wr) return 1;
    return 0;
  endfunction

  // reference snoop behaviour, applied at the edge where the design samples it
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_sh <= 0; exp_sup <= 0; exp_dat <= '0;
    end else if (snp_valid && snp_cmd != 2'd3) begin
      int i;
      bit dirty;
      i = int'(snp_addr[2:0]);
      dirty = (m_st[i] == MM) || (m_st[i] == MO);
      if (m_st[i] != MI && m_tag[i] == snp_addr[9:3]) begin
        exp_sh  <= 1;
        exp_sup <= dirty && (snp_cmd != 2'd2);
        exp_dat <= m_dat[i];
        m_st[i] = (snp_cmd == 2'd0) ? (dirty ? MO : MS) : MI;
      end else begin
        exp_sh <= 0; exp_sup <= 0;
      end
    end else begin
      exp_sh <= 0; exp_sup <= 0;
    end
  end

  // per-cycle comparison of snoop response against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(snp_shared == exp_sh, "R8", "snoop holding flag", snp_shared, exp_sh);
      check(snp_supply == exp_sup, "R9", "snoop supply flag", snp_supply, exp_sup);
      if (exp_sup) check(snp_data == exp_dat, "R10", "snoop data", snp_data, exp_dat);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=50000", cycles);
      finish_run();
    end
  end

  task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    @(negedge clk);
  endtask

  // smode: 0 none, 1 snoop during lookup, 2 snoop while waiting for grant
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit ack_sh, input int smode, input logic [1:0] sc,
                        input logic [AW-1:0] sa, input string req, input int exp_tx);
    int ntx = 0;
    int guard = 0;
    bit done = 0;
    bit snooped = 0;
    int i = int'(a[2:0]);
    @(negedge clk);
    check(req_ready == 1, "R2", "ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R2", "ready after accept", req_ready, 0);
    if (smode == 1) begin
      snp_valid = 1; snp_cmd = sc; snp_addr = sa; snooped = 1;
    end
    while (!done && guard < 300) begin
      guard++;
      @(negedge clk);
      if (snp_valid) snp_valid = 0;
      if (mst_ack) mst_ack = 0;
      if (mst_gnt) mst_gnt = 0;
      if (rsp_valid) begin
        if (ntx == 0) begin
          check(plan(wr, a) == -1, req, "completed without bus", 0, 1);
          if (wr) begin m_st[i] = MM; m_dat[i] = wd; end
        end
        check(rsp_rdata == (wr ? wd : m_dat[i]), req, "response data", rsp_rdata,
              wr ? wd : m_dat[i]);
        check(req_ready == 1, "R2", "ready with response", req_ready, 1);
        done = 1;
      end else if (mst_valid) begin
        int e = plan(wr, a);
        int v = (m_st[i] == MI) ? 0 : {m_tag[i], a[2:0]};
        check(int'(mst_cmd) == e, req, "bus command", mst_cmd, e);
        if (e == 3) begin
          check(mst_addr == AW'(v), "R7", "writeback address", mst_addr, v);
          check(mst_wdata == m_dat[i], "R7", "writeback data", mst_wdata, m_dat[i]);
          mem[v] = mst_wdata;
          m_st[i] = MI;
        end else begin
          check(mst_addr == a, req, "bus address", mst_addr, a);
          mst_ack_data = mem_rd(a);
          m_tag[i] = a[9:3];
          if (e == 0) begin m_st[i] = ack_sh ? MS : ME; m_dat[i] = mst_ack_data; end
          else begin m_st[i] = MM; m_dat[i] = wd; end
        end
        mst_ack_shared = ack_sh;
        mst_ack = 1;
        ntx++;
      end else if (mst_req) begin
        if (smode == 2 && !snooped) begin
          snp_valid = 1; snp_cmd = sc; snp_addr = sa; snooped = 1;
        end else begin
          mst_gnt = 1;
        end
      end
    end
    check(done, req, "request completed", done, 1);
    check(ntx == exp_tx, req, "bus transaction count", ntx, exp_tx);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin m_st[k] = MI; m_tag[k] = '0; m_dat[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1 && rsp_valid == 0, "R1", "idle after reset", {req_ready, rsp_valid}, 2);
    check(mst_req == 0 && mst_valid == 0, "R1", "bus quiet after reset", {mst_req, mst_valid}, 0);
    do_snoop(2'd0, 10'h010);
    access(0, 10'h011, '0, 0, 0, 0, 0, "R1", 1);
    // R3: read hit, then R8 exclusive -> shared
    access(0, 10'h011, '0, 0, 0, 0, 0, "R3", 0);
    do_snoop(2'd0, 10'h011);
    // R5: shared -> upgrade; then dirty supplied, owned -> upgrade
    access(1, 10'h011, 16'h1111, 0, 0, 0, 0, "R5", 1);
    do_snoop(2'd0, 10'h011);
    access(1, 10'h011, 16'h2222, 0, 0, 0, 0, "R5", 1);
    // R6: write miss
    access(1, 10'h022, 16'h3333, 0, 0, 0, 0, "R6", 1);
    // R7: dirty victim then refill; clean victim dropped
    access(0, 10'h032, '0, 1, 0, 0, 0, "R7", 2);
    access(0, 10'h042, '0, 0, 0, 0, 0, "R7", 1);
    // R4: write to exclusive stays local; R9 read-for-ownership steals it
    access(1, 10'h042, 16'h4444, 0, 0, 0, 0, "R4", 0);
    access(1, 10'h042, 16'h4545, 0, 0, 0, 0, "R4", 0);
    do_snoop(2'd1, 10'h042);
    access(0, 10'h042, '0, 0, 0, 0, 0, "R9", 1);
    // R10: writeback snoop ignored, upgrade snoop invalidates
    access(0, 10'h013, '0, 0, 0, 0, 0, "R3", 1);
    access(1, 10'h013, 16'h5555, 0, 0, 0, 0, "R4", 0);
    do_snoop(2'd3, 10'h013);
    do_snoop(2'd0, 10'h013);
    do_snoop(2'd2, 10'h013);
    access(0, 10'h013, '0, 1, 0, 0, 0, "R10", 1);
    do_snoop(2'd0, 10'h033);
    // R12: snoop in the lookup cycle wins, read then misses
    access(0, 10'h011, '0, 0, 1, 2'd1, 10'h011, "R12", 1);
    // R12: shared line invalidated while waiting for grant -> read-for-ownership
    access(0, 10'h055, '0, 1, 0, 0, 0, "R3", 1);
    access(1, 10'h055, 16'h6666, 0, 2, 2'd2, 10'h055, "R12", 1);
    do_snoop(2'd0, 10'h055);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule